// File: doc/BRIEF.md
# Headset Power-Mode Sequencer

This block steps a headset audio output stage between its power states: off, a module-by-module power-up, standby, a driver wake-up window, active, and a module-by-module power-down. A chip-enable input starts power-up. The block then switches on the internal module enables one at a time: the reference, then the PLL, then the charge pump, then both DACs. Each step waits a settle count that software programs. Once the DACs are on, the block rests in standby. A left or right headset request then turns on the matching driver. After a fixed wake-up delay, which is derived from the reference-clock rate and a delay in milliseconds, the block goes active. When chip enable is cleared, the modules are switched off in reverse order.

The enable vector that the sequencer writes also acts as the status of the modules. While the block rests in standby or active, a software clear strobe may switch off individual circuits that are not used. In parallel, the block decodes chip enable, the high-impedance request and the headset request into an output mode. It flags the illegal combinations and mutes the output whenever the path is not fully active.

Top module: `pwr_mode_sequencer`

## Requirements
- R1: After reset, pwrState is 0 (off), modEn is 0, outMode is 0 (shutdown), modeErr is 0 and muteOut is 1.
- R2: pwrState encodings are: 0 off, 1 power-up, 2 standby, 3 wake, 4 active, 5 power-down. The modEn bits are: 0 reference, 1 PLL, 2 charge pump, 3 DAC left, 4 DAC right, 5 driver left, 6 driver right. At the clock edge that samples chipOn=1 in off, the state becomes power-up. With settle value S, modEn gains bit 0, then bit 1, then bit 2, then bits 3 and 4 together. These steps fall S+1, 2(S+1), 3(S+1) and 4(S+1) edges after that edge. The last step also enters standby.
- R3: In standby, when chipOn=1, hiZReq=0 and at least one driver request is set, the next edge enters wake and sets the driver bits of the requested sides. The state becomes active WAKE_MS*REF_KHZ edges after wake was entered.
- R4: In active, when both driver requests are low, the next edge returns to standby and clears both driver bits.
- R5: Clearing chipOn in any state other than off or power-down enters power-down at the next edge. The groups are then cleared every S+1 edges in this order: drivers, DACs, charge pump, PLL, reference. The state becomes off on the edge that clears the reference, and modEn is 0 whenever the state is off.
- R6: A software clear (swClrValid with a bit mask) clears the selected modEn bits at the next edge only while the state is standby or active. In every other state it has no effect.
- R7: outMode is registered one edge after its inputs, where hs is drvReqL OR drvReqR. The decoding is: chip 0 / HiZ 0 gives 0 (shutdown) for either hs; chip 0 / HiZ 1 / hs 0 gives 1 (high impedance); chip 1 / HiZ 0 / hs 0 gives 2 (active, headset off); chip 1 / HiZ 0 / hs 1 gives 3 (active). Every other combination gives 4 (invalid).
- R8: When outMode is 4, modeErr is 1 and muteOut is 1. While hiZReq is 1 in standby, the block does not enter wake.
- R9: muteOut is 0 only when the state is active and outMode is 3. In particular, the high-impedance mode and the wake window are muted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipOn | input | 1 | Chip enable; a rising level starts power-up, a low level starts power-down |
| hiZReq | input | 1 | Request for high-impedance output |
| drvReqL | input | 1 | Left headset driver request |
| drvReqR | input | 1 | Right headset driver request |
| settleCycles | input | CNT_W | Extra wait cycles between sequencing steps |
| swClrValid | input | 1 | One-cycle software clear strobe |
| swClrBits | input | 7 | modEn bits to clear with the strobe |
| pwrState | output | 3 | Current power state |
| modEn | output | 7 | Module enable and status vector |
| outMode | output | 3 | Decoded output mode |
| modeErr | output | 1 | Illegal mode combination |
| muteOut | output | 1 | Output mute |

## Verification
The bench builds the block with CNT_W=4, REF_KHZ=4 and WAKE_MS=3. This gives a 12-cycle wake window, so the exact edge on which the state becomes active can be checked cycle by cycle. It runs power-up and power-down with a settle value of 2, so every step of both orderings can be sampled on its own edge, and it repeats power-up with a settle value of 0 to cover the back-to-back step boundary. These short windows also leave room to probe the software clear in every state, to abort a wake window, and to walk all eight mode combinations in one run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NMOD = 7;
  localparam int NGRP = 5;

  localparam int IDX_REF  = 0;
  localparam int IDX_PLL  = 1;
  localparam int IDX_CP   = 2;
  localparam int IDX_DACL = 3;
  localparam int IDX_DACR = 4;
  localparam int IDX_DRVL = 5;
  localparam int IDX_DRVR = 6;

  localparam logic [2:0] GRP_LAST_UP = 3'd3;
  localparam logic [2:0] GRP_DRV     = 3'd4;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_UP   = 3'd1,
    PS_STBY = 3'd2,
    PS_WAKE = 3'd3,
    PS_ACT  = 3'd4,
    PS_DOWN = 3'd5
  } pwrState_e;

  typedef enum logic [2:0] {
    OM_SHUT     = 3'd0,
    OM_HIZ      = 3'd1,
    OM_ON_HSOFF = 3'd2,
    OM_ON       = 3'd3,
    OM_BAD      = 3'd4
  } outMode_e;

  typedef struct packed {
    logic            setEn;
    logic            clrEn;
    logic            swOk;
    logic [NMOD-1:0] mask;
  } enStrobe_t;

  function automatic logic [NMOD-1:0] grpMask(input logic [2:0] grp);
    logic [NMOD-1:0] m;
    m = '0;
    case (grp)
      3'd0: m[IDX_REF] = 1'b1;
      3'd1: m[IDX_PLL] = 1'b1;
      3'd2: m[IDX_CP]  = 1'b1;
      3'd3: begin
        m[IDX_DACL] = 1'b1;
        m[IDX_DACR] = 1'b1;
      end
      3'd4: begin
        m[IDX_DRVL] = 1'b1;
        m[IDX_DRVR] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic outMode_e decodeMode(input logic chip, input logic hiz, input logic hs);
    outMode_e r;
    if (!chip) begin
      if (!hiz)    r = OM_SHUT;
      else if (!hs) r = OM_HIZ;
      else          r = OM_BAD;
    end else if (hiz) begin
      r = OM_BAD;
    end else if (hs) begin
      r = OM_ON;
    end else begin
      r = OM_ON_HSOFF;
    end
    return r;
  endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WAKE_CYCLES = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipOn,
  input  logic             hiZReq,
  input  logic             drvReqL,
  input  logic             drvReqR,
  input  logic [CNT_W-1:0] settleCycles,
  output pwrState_e        state,
  output enStrobe_t        strobe
);

  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam int CW     = (CNT_W > WAKE_W) ? CNT_W : WAKE_W;
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  pwrState_e   nState;
  logic [2:0]  stepIdx, nStep;
  logic [CW-1:0] cnt, nCnt;
  logic        settleHit, wakeHit, anyReq;
  logic [NMOD-1:0] reqMask;

  assign settleHit = (cnt == CW'(settleCycles));
  assign wakeHit   = (cnt == WAKE_LAST);
  assign anyReq    = drvReqL | drvReqR;

  always_comb begin
    reqMask = '0;
    reqMask[IDX_DRVL] = drvReqL;
    reqMask[IDX_DRVR] = drvReqR;
  end

  always_comb begin
    nState = state;
    nStep  = stepIdx;
    nCnt   = cnt;
    strobe = '0;
    case (state)
      PS_OFF: begin
        if (chipOn) begin
          nState = PS_UP;
          nStep  = 3'd0;
          nCnt   = '0;
        end
      end
      PS_UP: begin
        if (!chipOn) begin
          nState = PS_DOWN;
          nStep  = GRP_DRV;
          nCnt   = '0;
        end else if (settleHit) begin
          strobe.setEn = 1'b1;
          strobe.mask  = grpMask(stepIdx);
          nCnt         = '0;
          if (stepIdx == GRP_LAST_UP) nState = PS_STBY;
          else                        nStep  = stepIdx + 3'd1;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
      PS_STBY: begin
        strobe.swOk = 1'b1;
        if (!chipOn) begin
          nState = PS_DOWN;
          nStep  = GRP_DRV;
          nCnt   = '0;
        end else if (anyReq && !hiZReq) begin
          nState       = PS_WAKE;
          nCnt         = '0;
          strobe.setEn = 1'b1;
          strobe.mask  = reqMask;
        end
      end
      PS_WAKE: begin
        if (!chipOn) begin
          nState = PS_DOWN;
          nStep  = GRP_DRV;
          nCnt   = '0;
        end else if (wakeHit) begin
          nState = PS_ACT;
          nCnt   = '0;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
      PS_ACT: begin
        strobe.swOk = 1'b1;
        if (!chipOn) begin
          nState = PS_DOWN;
          nStep  = GRP_DRV;
          nCnt   = '0;
        end else if (!anyReq) begin
          nState       = PS_STBY;
          strobe.clrEn = 1'b1;
          strobe.mask  = grpMask(GRP_DRV);
        end
      end
      PS_DOWN: begin
        if (settleHit) begin
          strobe.clrEn = 1'b1;
          strobe.mask  = grpMask(stepIdx);
          nCnt         = '0;
          if (stepIdx == 3'd0) nState = PS_OFF;
          else                 nStep  = stepIdx - 3'd1;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
      default: nState = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_OFF;
      stepIdx <= 3'd0;
      cnt     <= '0;
    end else begin
      state   <= nState;
      stepIdx <= nStep;
      cnt     <= nCnt;
    end
  end

  AST_ACT_FROM_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_ACT) |-> ($past(state) == PS_WAKE || $past(state) == PS_ACT)); // R3

  AST_OFF_FROM_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_OFF && $past(state) != PS_OFF) |-> ($past(state) == PS_DOWN)); // R5

  AST_NO_WAKE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STBY && hiZReq) |=> (state != PS_WAKE)); // R8

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_UP) |-> (stepIdx <= GRP_LAST_UP)); // R2

endmodule

// File: rtl/pwr_seq_enables.sv
module pwr_seq_enables
  import pwr_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  enStrobe_t       strobe,
  input  logic            swClrValid,
  input  logic [NMOD-1:0] swClrBits,
  output logic [NMOD-1:0] modEn
);

  for (genvar i = 0; i < NMOD; i++) begin : g_bit
    logic setHit, seqClr, swClr;
    assign setHit = strobe.setEn & strobe.mask[i];
    assign seqClr = strobe.clrEn & strobe.mask[i];
    assign swClr  = strobe.swOk & swClrValid & swClrBits[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                modEn[i] <= 1'b0;
      else if (setHit)          modEn[i] <= 1'b1;
      else if (seqClr || swClr) modEn[i] <= 1'b0;
    end
  end

  AST_NO_RISE_WITHOUT_SET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setEn |=> ((modEn & ~$past(modEn)) == '0)); // R2

  AST_NO_FALL_WITHOUT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrEn && !strobe.swOk) |=> (($past(modEn) & ~modEn) == '0)); // R6

endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipOn,
  input  logic      hiZReq,
  input  logic      hsReq,
  input  pwrState_e state,
  output outMode_e  outMode,
  output logic      modeErr,
  output logic      muteOut
);

  outMode_e nMode;
  assign nMode = decodeMode(chipOn, hiZReq, hsReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMode <= OM_SHUT;
      modeErr <= 1'b0;
    end else begin
      outMode <= nMode;
      modeErr <= (nMode == OM_BAD);
    end
  end

  assign muteOut = !((state == PS_ACT) && (outMode == OM_ON));

  AST_ERR_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> muteOut); // R8

  AST_HIZ_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OM_HIZ) |-> muteOut); // R9

  AST_WAKE_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_WAKE) |-> muteOut); // R9

endmodule

// File: rtl/pwr_mode_sequencer.sv
module pwr_mode_sequencer
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int REF_KHZ = 32,
  parameter int WAKE_MS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipOn,
  input  logic             hiZReq,
  input  logic             drvReqL,
  input  logic             drvReqR,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic             swClrValid,
  input  logic [6:0]       swClrBits,
  output logic [2:0]       pwrState,
  output logic [6:0]       modEn,
  output logic [2:0]       outMode,
  output logic             modeErr,
  output logic             muteOut
);

  localparam int WAKE_CYCLES = REF_KHZ * WAKE_MS;

  pwrState_e stateW;
  enStrobe_t strobeW;
  outMode_e  modeW;

  pwr_seq_fsm #(.CNT_W(CNT_W), .WAKE_CYCLES(WAKE_CYCLES)) uFsm (
    .clk(clk), .rstN(rstN), .chipOn(chipOn), .hiZReq(hiZReq),
    .drvReqL(drvReqL), .drvReqR(drvReqR), .settleCycles(settleCycles),
    .state(stateW), .strobe(strobeW)
  );

  pwr_seq_enables uEn (
    .clk(clk), .rstN(rstN), .strobe(strobeW),
    .swClrValid(swClrValid), .swClrBits(swClrBits), .modEn(modEn)
  );

  pwr_mode_decode uMode (
    .clk(clk), .rstN(rstN), .chipOn(chipOn), .hiZReq(hiZReq),
    .hsReq(drvReqL | drvReqR), .state(stateW),
    .outMode(modeW), .modeErr(modeErr), .muteOut(muteOut)
  );

  assign pwrState = stateW;
  assign outMode  = modeW;

  AST_OFF_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stateW == PS_OFF) |-> (modEn == '0)); // R5

endmodule

// File: tb/pwr_mode_sequencer_test.sv
module pwr_mode_sequencer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipOn = 1'b0, hiZReq = 1'b0, drvReqL = 1'b0, drvReqR = 1'b0;
  logic [3:0] settleCycles = 4'd2;
  logic       swClrValid = 1'b0;
  logic [6:0] swClrBits = 7'd0;
  logic [2:0] pwrState, outMode;
  logic [6:0] modEn;
  logic       modeErr, muteOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwr_mode_sequencer #(.CNT_W(4), .REF_KHZ(4), .WAKE_MS(3)) uut (
    .clk(clk), .rstN(rstN), .chipOn(chipOn), .hiZReq(hiZReq),
    .drvReqL(drvReqL), .drvReqR(drvReqR), .settleCycles(settleCycles),
    .swClrValid(swClrValid), .swClrBits(swClrBits),
    .pwrState(pwrState), .modEn(modEn), .outMode(outMode),
    .modeErr(modeErr), .muteOut(muteOut)
  );

  // {chip, hiz, hs, err, mode[2:0]}
  localparam logic [6:0] MODE_VEC [8] = '{
    7'b000_0_000, 7'b001_0_000, 7'b010_0_001, 7'b011_1_100,
    7'b100_0_010, 7'b101_0_011, 7'b110_1_100, 7'b111_1_100
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 state", pwrState, 0);
    check("R1 modEn", modEn, 0);
    check("R1 outMode", outMode, 0);
    check("R1 modeErr", modeErr, 0);
    check("R1 mute", muteOut, 1);
    rstN = 1'b1;
    tick(1);
    check("R1 state after release", pwrState, 0);

    // R7 / R8 mode table
    for (int i = 0; i < 8; i++) begin
      chipOn  = MODE_VEC[i][6];
      hiZReq  = MODE_VEC[i][5];
      drvReqL = MODE_VEC[i][4];
      tick(1);
      check("R7 outMode", outMode, MODE_VEC[i][2:0]);
      check("R8 modeErr", modeErr, MODE_VEC[i][3]);
      check("R9 mute when not active", muteOut, 1);
    end

    rstN = 1'b0; chipOn = 0; hiZReq = 0; drvReqL = 0; drvReqR = 0;
    tick(2);
    rstN = 1'b1;
    tick(1);

    // R2 power-up order, settle 2
    settleCycles = 4'd2;
    chipOn = 1'b1;
    tick(3);
    check("R2 up state", pwrState, 1);
    check("R2 nothing yet", modEn, 7'h00);
    tick(1); check("R2 ref", modEn, 7'h01);
    tick(2); check("R2 pll not early", modEn, 7'h01);
    tick(1); check("R2 pll", modEn, 7'h03);
    tick(3); check("R2 cp", modEn, 7'h07);
    tick(3); check("R2 dacs", modEn, 7'h1F);
    check("R2 standby", pwrState, 2);

    // R8 no wake while HiZ
    hiZReq = 1'b1; drvReqL = 1'b1;
    tick(1);
    check("R8 err", modeErr, 1);
    check("R8 mute", muteOut, 1);
    tick(4);
    check("R8 stays standby", pwrState, 2);

    // R3 wake timing
    hiZReq = 1'b0;
    tick(1);
    check("R3 wake", pwrState, 3);
    check("R3 left driver", modEn, 7'h3F);
    check("R9 mute in wake", muteOut, 1);
    tick(11); check("R3 still wake", pwrState, 3);
    tick(1);  check("R3 active", pwrState, 4);
    check("R9 unmuted", muteOut, 0);
    check("R7 mode on", outMode, 3);

    // R6 software clear in active
    swClrValid = 1'b1; swClrBits = 7'h10;
    tick(1);
    swClrValid = 1'b0;
    check("R6 clear in active", modEn, 7'h2F);

    // R4 drop requests
    drvReqL = 1'b0;
    tick(1);
    check("R4 standby", pwrState, 2);
    check("R4 drivers off", modEn, 7'h0F);
    check("R7 hs off mode", outMode, 2);

    // R5 power-down reverse order
    chipOn = 1'b0;
    tick(1);
    check("R5 down", pwrState, 5);
    check("R5 hold", modEn, 7'h0F);
    tick(6); check("R5 dacs off", modEn, 7'h07);
    tick(3); check("R5 cp off", modEn, 7'h03);
    tick(3); check("R5 pll off", modEn, 7'h01);
    check("R5 still down", pwrState, 5);
    tick(3); check("R5 ref off", modEn, 7'h00);
    check("R5 off", pwrState, 0);

    // R6 clear ignored during power-up
    chipOn = 1'b1;
    tick(4); check("R2 ref again", modEn, 7'h01);
    swClrValid = 1'b1; swClrBits = 7'h01;
    tick(1);
    swClrValid = 1'b0;
    check("R6 ignored in power-up", modEn, 7'h01);
    tick(8); check("R2 standby again", modEn, 7'h1F);
    swClrValid = 1'b1; swClrBits = 7'h02;
    tick(1);
    swClrValid = 1'b0;
    check("R6 clear in standby", modEn, 7'h1D);

    // R3 both drivers, then abort wake
    drvReqL = 1'b1; drvReqR = 1'b1;
    tick(1);
    check("R3 both drivers", modEn, 7'h7D);
    check("R3 wake both", pwrState, 3);
    chipOn = 1'b0;
    tick(1);
    check("R5 abort wake", pwrState, 5);
    tick(15);
    check("R5 off after abort", pwrState, 0);
    check("R5 all clear", modEn, 7'h00);

    // R2 settle 0
    settleCycles = 4'd0;
    drvReqL = 1'b0; drvReqR = 1'b0;
    chipOn = 1'b1;
    tick(1); check("R2 up s0", pwrState, 1);
    tick(1); check("R2 ref s0", modEn, 7'h01);
    tick(3); check("R2 dacs s0", modEn, 7'h1F);
    check("R2 standby s0", pwrState, 2);

    summary();
    $finish;
  end

endmodule